// File: doc/BRIEF.md
# System Instruction Executor: CSR Access and Privilege Return

This block executes the system-opcode instructions (major opcode 0x73) of a core with three privilege levels. It owns the privilege mode, the machine and supervisor status words, the two saved return addresses, the address-translation control word, the paging-enable flag and a small file of general CSRs. It carries out the six read-modify-write CSR forms, environment call, breakpoint and the two return instructions.

The surrounding pipeline presents one decoded-ready instruction word with the value of its first source register and a valid strobe. The unit answers in the same cycle. It reports the old CSR value and a write enable for the destination register. On a return it reports a redirect and the target PC. On a trap request it reports an exception and its cause code. Its internal state advances on the clock edge at which the strobe is high.

Top module: `sysop_unit`

## Requirements
- R1: Swap forms (funct3 1 with register operand, funct3 5 with the 5-bit rs1 field zero-extended as operand) write the operand into the CSR addressed by bits 31:20 and return the old value. Named CSRs sit at 0x300 (machine status), 0x100 (supervisor status), 0x341 (machine return PC), 0x141 (supervisor return PC) and 0x180 (translation control). Any other address selects general entry addr[1:0] of a 4-entry file.
- R2: Set forms (funct3 2 and 6) write old OR operand. Clear forms (funct3 3 and 7) write old AND NOT operand. Both return the old value.
- R3: With destination index 0 the register write enable stays low, but the CSR write still happens.
- R4: A swap form aimed at 0x180 sets paging on exactly when bits 63:60 of the new value equal 8, and clears it otherwise. Set and clear forms on 0x180 leave paging unchanged.
- R5: funct3 0 with rs2 0 and funct7 0 raises cause 8 in user mode (encoding 00), 9 in supervisor (01) and 11 in machine (11). rs2 1 with funct7 0 raises cause 3. Neither changes any state.
- R6: Supervisor return (rs2 2, funct7 0x08), legal in supervisor or machine mode, redirects to the supervisor return PC. It sets the mode to supervisor if supervisor-status bit 8 is 1, else to user. It then writes bit 5 into bit 1, sets bit 5 and clears bit 8.
- R7: Machine return (rs2 2, funct7 0x18), legal only in machine mode, redirects to the machine return PC. It takes the mode from machine-status bits 12:11 (00 user, 01 supervisor, 11 machine, 10 user). It then writes bit 7 into bit 3, sets bit 7 and clears bits 12:11. The new mode comes from the bits as they were before the rewrite.
- R8: A return below its required privilege raises cause 2, gives no redirect and changes no state.
- R9: Without the valid strobe, no output asserts and no state changes.
- R10: After reset the mode is machine, paging is off and every CSR reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Value of the first source register |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_val_o | output | XLEN | Old CSR value for the destination |
| redirect_o | output | 1 | Return taken, fetch from new_pc_o |
| new_pc_o | output | XLEN | Return target |
| mode_o | output | 2 | Current privilege mode |
| exc_valid_o | output | 1 | Exception raised by this instruction |
| exc_code_o | output | 4 | Exception cause code |
| paging_on_o | output | 1 | Address translation enabled |

## Verification
Two actions share one clock edge in this block. A CSR instruction returns the old value and commits the new value together. A return instruction changes the privilege mode and rewrites the same status field that selects that mode. The bench sweeps every CSR form over every named address and several general addresses. It compares the returned old value against a running arithmetic model, then reads the CSR back with a set-by-zero to confirm the committed value. For returns it primes status bits 12:11 or bit 8 and sets the enable bits to opposite values. It then checks that the new mode follows the pre-edge field while the read-back status shows the field cleared and the enable bits moved.

// File: rtl/sysop_pkg.sv
package sysop_pkg;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [11:0] A_SSTAT = 12'h100;
  localparam logic [11:0] A_SEPC  = 12'h141;
  localparam logic [11:0] A_XLATE = 12'h180;
  localparam logic [11:0] A_MSTAT = 12'h300;
  localparam logic [11:0] A_MEPC  = 12'h341;

  localparam logic [3:0] CAUSE_ILLEGAL = 4'd2;
  localparam logic [3:0] CAUSE_BRK     = 4'd3;
  localparam logic [3:0] CAUSE_ECALL_U = 4'd8;
  localparam logic [3:0] CAUSE_ECALL_S = 4'd9;
  localparam logic [3:0] CAUSE_ECALL_M = 4'd11;

  typedef enum logic [2:0] {
    OP_NONE, OP_CSR, OP_ECALL, OP_EBRK, OP_SRET, OP_MRET
  } sysop_e;

  typedef struct packed {
    sysop_e      op;
    logic [1:0]  kind;    // 1 swap, 2 set, 3 clear
    logic        use_imm;
    logic [4:0]  rd;
    logic [4:0]  src;
    logic [11:0] addr;
  } sysop_dec_t;

endpackage

// File: rtl/sysop_decode.sv
module sysop_decode
  import sysop_pkg::*;
(
  input  logic [31:0] insn,
  output sysop_dec_t  dec
);
  logic [2:0] f3;
  logic [4:0] rs2;
  logic [6:0] f7;

  assign f3  = insn[14:12];
  assign rs2 = insn[24:20];
  assign f7  = insn[31:25];

  always_comb begin
    dec.op      = OP_NONE;
    dec.kind    = f3[1:0];
    dec.use_imm = f3[2];
    dec.rd      = insn[11:7];
    dec.src     = insn[19:15];
    dec.addr    = insn[31:20];
    if (insn[6:0] == 7'h73) begin
      if (f3[1:0] != 2'b00) begin
        dec.op = OP_CSR;
      end else if (f3 == 3'd0) begin
        if (rs2 == 5'd0 && f7 == 7'h00)      dec.op = OP_ECALL;
        else if (rs2 == 5'd1 && f7 == 7'h00) dec.op = OP_EBRK;
        else if (rs2 == 5'd2 && f7 == 7'h08) dec.op = OP_SRET;
        else if (rs2 == 5'd2 && f7 == 7'h18) dec.op = OP_MRET;
      end
    end
  end
endmodule

// File: rtl/sysop_csr_store.sv
module sysop_csr_store
  import sysop_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NGEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [11:0]     waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic            pg_we,
  input  logic            pg_val,
  input  logic [11:0]     raddr,
  output logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] mstat_o,
  output logic [XLEN-1:0] sstat_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] sepc_o,
  output logic            paging_o
);
  localparam int GW = (NGEN > 1) ? $clog2(NGEN) : 1;

  logic [XLEN-1:0] mstat_q, mstat_d, sstat_q, sstat_d;
  logic [XLEN-1:0] mepc_q, mepc_d, sepc_q, sepc_d, xlate_q, xlate_d;
  logic            pg_q, pg_d;
  logic [XLEN-1:0] gen_rd [NGEN];
  logic            named_w;

  function automatic logic is_named(input logic [11:0] a);
    return (a == A_MSTAT) || (a == A_SSTAT) || (a == A_MEPC) ||
           (a == A_SEPC)  || (a == A_XLATE);
  endfunction

  assign named_w = is_named(waddr);

  always_comb begin
    mstat_d = (we && waddr == A_MSTAT) ? wdata : mstat_q;
    sstat_d = (we && waddr == A_SSTAT) ? wdata : sstat_q;
    mepc_d  = (we && waddr == A_MEPC)  ? wdata : mepc_q;
    sepc_d  = (we && waddr == A_SEPC)  ? wdata : sepc_q;
    xlate_d = (we && waddr == A_XLATE) ? wdata : xlate_q;
    pg_d    = pg_we ? pg_val : pg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstat_q <= '0; sstat_q <= '0; mepc_q <= '0;
      sepc_q  <= '0; xlate_q <= '0; pg_q   <= 1'b0;
    end else begin
      mstat_q <= mstat_d; sstat_q <= sstat_d; mepc_q <= mepc_d;
      sepc_q  <= sepc_d;  xlate_q <= xlate_d; pg_q   <= pg_d;
    end
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    logic [XLEN-1:0] q, d;
    logic            hit;
    assign hit = we && !named_w && (waddr[GW-1:0] == GW'(g));
    always_comb d = hit ? wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign gen_rd[g] = q;
  end

  always_comb begin
    case (raddr)
      A_MSTAT: rdata = mstat_q;
      A_SSTAT: rdata = sstat_q;
      A_MEPC:  rdata = mepc_q;
      A_SEPC:  rdata = sepc_q;
      A_XLATE: rdata = xlate_q;
      default: rdata = gen_rd[raddr[GW-1:0]];
    endcase
  end

  assign mstat_o  = mstat_q;
  assign sstat_o  = sstat_q;
  assign mepc_o   = mepc_q;
  assign sepc_o   = sepc_q;
  assign paging_o = pg_q;
endmodule

// File: rtl/sysop_ret.sv
module sysop_ret
  import sysop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  sysop_e          op,
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] mstat,
  input  logic [XLEN-1:0] sstat,
  input  logic [XLEN-1:0] mepc,
  input  logic [XLEN-1:0] sepc,
  output logic            take,
  output logic            illegal,
  output logic [1:0]      tgt_mode,
  output logic [XLEN-1:0] tgt_pc,
  output logic [11:0]     st_addr,
  output logic [XLEN-1:0] st_data
);
  always_comb begin
    take     = 1'b0;
    illegal  = 1'b0;
    tgt_mode = mode;
    tgt_pc   = '0;
    st_addr  = A_MSTAT;
    st_data  = mstat;
    case (op)
      OP_SRET: begin
        if (mode == PRIV_U) begin
          illegal = 1'b1;
        end else begin
          take       = 1'b1;
          tgt_pc     = sepc;
          tgt_mode   = sstat[8] ? PRIV_S : PRIV_U;
          st_addr    = A_SSTAT;
          st_data    = sstat;
          st_data[1] = sstat[5];
          st_data[5] = 1'b1;
          st_data[8] = 1'b0;
        end
      end
      OP_MRET: begin
        if (mode != PRIV_M) begin
          illegal = 1'b1;
        end else begin
          take   = 1'b1;
          tgt_pc = mepc;
          case (mstat[12:11])
            2'b01:   tgt_mode = PRIV_S;
            2'b11:   tgt_mode = PRIV_M;
            default: tgt_mode = PRIV_U;
          endcase
          st_data[3]     = mstat[7];
          st_data[7]     = 1'b1;
          st_data[12:11] = 2'b00;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sysop_unit.sv
module sysop_unit
  import sysop_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NGEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_val_i,
  output logic            rd_we_o,
  output logic [4:0]      rd_idx_o,
  output logic [XLEN-1:0] rd_val_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] new_pc_o,
  output logic [1:0]      mode_o,
  output logic            exc_valid_o,
  output logic [3:0]      exc_code_o,
  output logic            paging_on_o
);
  localparam int MTOP = XLEN - 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  sysop_dec_t      dec;
  logic [XLEN-1:0] old_val, operand, new_val;
  logic [XLEN-1:0] mstat, sstat, mepc, sepc;
  logic            csr_go, ret_take, ret_ill, ret_go;
  logic [1:0]      ret_mode, mode_q, mode_d;
  logic [XLEN-1:0] ret_pc, st_data, wdata;
  logic [11:0]     st_addr, waddr;
  logic            we, pg_we, pg_val;
  logic            exc_hit;
  logic [3:0]      exc_code;

  sysop_decode u_dec (.insn(insn_i), .dec(dec));

  sysop_ret #(.XLEN(XLEN)) u_ret (
    .op(dec.op), .mode(mode_q), .mstat(mstat), .sstat(sstat),
    .mepc(mepc), .sepc(sepc), .take(ret_take), .illegal(ret_ill),
    .tgt_mode(ret_mode), .tgt_pc(ret_pc), .st_addr(st_addr), .st_data(st_data)
  );

  assign csr_go  = valid_i && (dec.op == OP_CSR);
  assign ret_go  = valid_i && ret_take;
  assign operand = dec.use_imm ? XLEN'(dec.src) : rs1_val_i;

  always_comb begin
    case (dec.kind)
      2'd2:    new_val = old_val | operand;
      2'd3:    new_val = old_val & ~operand;
      default: new_val = operand;
    endcase
  end

  assign we     = csr_go || ret_go;
  assign waddr  = csr_go ? dec.addr : st_addr;
  assign wdata  = csr_go ? new_val  : st_data;
  assign pg_we  = csr_go && (dec.addr == A_XLATE) && (dec.kind == 2'd1);
  assign pg_val = (new_val[XLEN-1:MTOP] == 4'd8);

  sysop_csr_store #(.XLEN(XLEN), .NGEN(NGEN)) u_store (
    .clk(clk), .rst_n(rst_i_n), .we(we), .waddr(waddr), .wdata(wdata),
    .pg_we(pg_we), .pg_val(pg_val), .raddr(dec.addr), .rdata(old_val),
    .mstat_o(mstat), .sstat_o(sstat), .mepc_o(mepc), .sepc_o(sepc),
    .paging_o(paging_on_o)
  );

  // privilege mode
  always_comb mode_d = ret_go ? ret_mode : mode_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_q <= PRIV_M;
    else          mode_q <= mode_d;
  end

  always_comb begin
    exc_hit  = 1'b0;
    exc_code = 4'd0;
    case (dec.op)
      OP_ECALL: begin
        exc_hit = 1'b1;
        case (mode_q)
          PRIV_U:  exc_code = CAUSE_ECALL_U;
          PRIV_S:  exc_code = CAUSE_ECALL_S;
          default: exc_code = CAUSE_ECALL_M;
        endcase
      end
      OP_EBRK: begin
        exc_hit  = 1'b1;
        exc_code = CAUSE_BRK;
      end
      OP_SRET, OP_MRET: begin
        exc_hit  = ret_ill;
        exc_code = ret_ill ? CAUSE_ILLEGAL : 4'd0;
      end
      default: ;
    endcase
  end

  assign rd_we_o     = csr_go && (dec.rd != 5'd0);
  assign rd_idx_o    = dec.rd;
  assign rd_val_o    = old_val;
  assign redirect_o  = ret_go;
  assign new_pc_o    = ret_pc;
  assign mode_o      = mode_q;
  assign exc_valid_o = valid_i && exc_hit;
  assign exc_code_o  = exc_code;
endmodule

// File: rtl/sysop_unit_chk.sv
module sysop_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic       rd_we_o,
  input logic [4:0] rd_idx_o,
  input logic       redirect_o,
  input logic       exc_valid_o,
  input logic [3:0] exc_code_o,
  input logic [1:0] mode_o,
  input logic       paging_on_o
);
  assert_idle_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(mode_o));

  assert_idle_paging_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(paging_on_o));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !(rd_we_o || redirect_o || exc_valid_o));

  assert_no_x0_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> rd_idx_o != 5'd0);

  assert_exc_keeps_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |=> $stable(mode_o));

  assert_exc_no_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |-> !redirect_o);

  assert_mode_change_only_on_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |=> $stable(mode_o));

  assert_cause_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |-> (exc_code_o == 4'd2 || exc_code_o == 4'd3 || exc_code_o == 4'd8 ||
                     exc_code_o == 4'd9 || exc_code_o == 4'd11));

  assert_mode_encoded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b10);
endmodule

bind sysop_unit sysop_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .rd_we_o(rd_we_o),
  .rd_idx_o(rd_idx_o), .redirect_o(redirect_o), .exc_valid_o(exc_valid_o),
  .exc_code_o(exc_code_o), .mode_o(mode_o), .paging_on_o(paging_on_o)
);

// File: tb/sim_sysop_unit.sv
module sim_sysop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = 32'h0;
  logic [63:0] rs1_val_i = 64'h0;
  logic        rd_we_o, redirect_o, exc_valid_o, paging_on_o;
  logic [4:0]  rd_idx_o;
  logic [63:0] rd_val_o, new_pc_o;
  logic [1:0]  mode_o;
  logic [3:0]  exc_code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sysop_unit #(.XLEN(64), .NGEN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .rs1_val_i(rs1_val_i), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
    .rd_val_o(rd_val_o), .redirect_o(redirect_o), .new_pc_o(new_pc_o),
    .mode_o(mode_o), .exc_valid_o(exc_valid_o), .exc_code_o(exc_code_o),
    .paging_on_o(paging_on_o)
  );

  // reference state
  logic [1:0]  m_mode;
  logic [63:0] m_ms, m_ss, m_mepc, m_sepc, m_xl;
  logic [63:0] m_gen [4];
  logic        m_pg;

  task automatic m_reset();
    m_mode = 2'b11; m_ms = 0; m_ss = 0; m_mepc = 0; m_sepc = 0; m_xl = 0; m_pg = 0;
    for (int i = 0; i < 4; i++) m_gen[i] = 0;
  endtask

  function automatic logic [63:0] m_read(input logic [11:0] a);
    case (a)
      12'h300: return m_ms;
      12'h100: return m_ss;
      12'h341: return m_mepc;
      12'h141: return m_sepc;
      12'h180: return m_xl;
      default: return m_gen[a[1:0]];
    endcase
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [63:0] v);
    case (a)
      12'h300: m_ms = v;
      12'h100: m_ss = v;
      12'h341: m_mepc = v;
      12'h141: m_sepc = v;
      12'h180: m_xl = v;
      default: m_gen[a[1:0]] = v;
    endcase
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] csr_ins(input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [4:0] s, input logic [11:0] a);
    return {a, s, f3, rd, 7'h73};
  endfunction

  function automatic logic [31:0] sys_ins(input logic [4:0] rs2, input logic [6:0] f7);
    return {f7, rs2, 5'd0, 3'd0, 5'd0, 7'h73};
  endfunction

  // issue one instruction, check same-cycle outputs, then post-edge state
  task automatic run(input logic [31:0] ins, input logic [63:0] rv, input string req);
    logic [2:0]  f3;
    logic [11:0] a;
    logic [63:0] old, opnd, nv, e_pc;
    logic        e_we, e_redir, e_exc, do_w, do_pg, pg_new;
    logic [3:0]  e_code;
    logic [1:0]  n_mode;
    logic [11:0] wa;
    logic [63:0] wv;
    f3 = ins[14:12]; a = ins[31:20];
    e_we = 0; e_redir = 0; e_exc = 0; e_code = 0; e_pc = 0; old = 0;
    do_w = 0; do_pg = 0; pg_new = 0; n_mode = m_mode; wa = 0; wv = 0; nv = 0;
    if (ins[6:0] == 7'h73) begin
      if (f3[1:0] != 2'b00) begin
        old  = m_read(a);
        opnd = f3[2] ? {59'd0, ins[19:15]} : rv;
        case (f3[1:0])
          2'd1: nv = opnd;
          2'd2: nv = old | opnd;
          default: nv = old & ~opnd;
        endcase
        e_we = (ins[11:7] != 0); do_w = 1; wa = a; wv = nv;
        if (a == 12'h180 && f3[1:0] == 2'd1) begin do_pg = 1; pg_new = (nv[63:60] == 4'd8); end
      end else if (f3 == 0) begin
        if (ins[24:20] == 0 && ins[31:25] == 0) begin
          e_exc = 1; e_code = (m_mode == 2'b00) ? 4'd8 : (m_mode == 2'b01) ? 4'd9 : 4'd11;
        end else if (ins[24:20] == 1 && ins[31:25] == 0) begin
          e_exc = 1; e_code = 4'd3;
        end else if (ins[24:20] == 2 && ins[31:25] == 7'h08) begin
          if (m_mode == 2'b00) begin e_exc = 1; e_code = 4'd2; end
          else begin
            e_redir = 1; e_pc = m_sepc; n_mode = m_ss[8] ? 2'b01 : 2'b00;
            wv = m_ss; wv[1] = m_ss[5]; wv[5] = 1; wv[8] = 0; wa = 12'h100; do_w = 1;
          end
        end else if (ins[24:20] == 2 && ins[31:25] == 7'h18) begin
          if (m_mode != 2'b11) begin e_exc = 1; e_code = 4'd2; end
          else begin
            e_redir = 1; e_pc = m_mepc;
            n_mode = (m_ms[12:11] == 2'b01) ? 2'b01 : (m_ms[12:11] == 2'b11) ? 2'b11 : 2'b00;
            wv = m_ms; wv[3] = m_ms[7]; wv[7] = 1; wv[12:11] = 0; wa = 12'h300; do_w = 1;
          end
        end
      end
    end
    @(negedge clk);
    insn_i = ins; rs1_val_i = rv; valid_i = 1'b1;
    #1;
    chk(req, "rd_we", rd_we_o, e_we);
    if (e_we) chk(req, "rd_val", rd_val_o, old);
    chk(req, "redirect", redirect_o, e_redir);
    if (e_redir) chk(req, "new_pc", new_pc_o, e_pc);
    chk(req, "exc_valid", exc_valid_o, e_exc);
    if (e_exc) chk(req, "exc_code", exc_code_o, e_code);
    @(posedge clk);
    if (do_w) m_write(wa, wv);
    if (do_pg) m_pg = pg_new;
    m_mode = n_mode;
    @(negedge clk);
    valid_i = 1'b0;
    #1;
    chk(req, "mode", mode_o, m_mode);
    chk(req, "paging", paging_on_o, m_pg);
  endtask

  // read-back through set-with-zero-immediate
  task automatic rd_back(input logic [11:0] a, input string req);
    run(csr_ins(3'd6, 5'd1, 5'd0, a), 64'h0, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_reset();
  endtask

  logic [11:0] addrs [9];
  logic [63:0] pats [3];

  initial begin
    addrs = '{12'h300, 12'h100, 12'h341, 12'h141, 12'h180, 12'h7C0, 12'h7C1, 12'h7C2, 12'h7C3};
    pats  = '{64'hA5A5_0F0F_1234_5678, 64'hFFFF_FFFF_0000_FFEA, 64'h0};
    m_reset();
    do_reset();

    // R10: reset state
    #1;
    chk("R10", "mode", mode_o, 2'b11);
    chk("R10", "paging", paging_on_o, 1'b0);
    chk("R10", "exc", exc_valid_o, 1'b0);
    for (int i = 0; i < 9; i++) rd_back(addrs[i], "R10");

    // R1/R2: every form over every address and pattern, read back after each
    for (int i = 0; i < 9; i++)
      for (int f = 1; f < 8; f++)
        for (int p = 0; p < 3; p++) begin
          if (f == 4) continue;
          run(csr_ins(3'(f), 5'(1 + p), (f > 4) ? pats[p][4:0] : 5'd7, addrs[i]),
              pats[p], ((f & 3) == 1) ? "R1" : "R2");
          rd_back(addrs[i], ((f & 3) == 1) ? "R1" : "R2");
        end

    // R3: destination 0 suppressed, CSR still written
    run(csr_ins(3'd1, 5'd0, 5'd0, 12'h7C2), 64'h0123_4567_89AB_CDEF, "R3");
    rd_back(12'h7C2, "R3");
    run(csr_ins(3'd5, 5'd0, 5'h15, 12'h7C1), 64'h0, "R3");
    rd_back(12'h7C1, "R3");

    // R4: paging follows mode field only on swap
    run(csr_ins(3'd1, 5'd2, 5'd0, 12'h180), 64'h8000_0000_0000_0042, "R4");
    run(csr_ins(3'd3, 5'd2, 5'd0, 12'h180), 64'hF000_0000_0000_0000, "R4");
    rd_back(12'h180, "R4");
    run(csr_ins(3'd2, 5'd2, 5'd0, 12'h180), 64'h9000_0000_0000_0000, "R4");
    run(csr_ins(3'd1, 5'd2, 5'd0, 12'h180), 64'h9000_0000_0000_0000, "R4");
    run(csr_ins(3'd1, 5'd2, 5'd0, 12'h180), 64'h8000_0000_0000_0000, "R4");
    run(csr_ins(3'd5, 5'd2, 5'd3, 12'h180), 64'h0, "R4");

    // R5: traps in machine mode
    run(sys_ins(5'd0, 7'h00), 64'h0, "R5");
    run(sys_ins(5'd1, 7'h00), 64'h0, "R5");
    rd_back(12'h300, "R5");

    // R7: machine return to supervisor, enable bits opposite
    run(csr_ins(3'd1, 5'd1, 5'd0, 12'h341), 64'h0000_0000_8000_1000, "R7");
    run(csr_ins(3'd1, 5'd1, 5'd0, 12'h141), 64'h0000_0000_8000_2000, "R7");
    run(csr_ins(3'd1, 5'd1, 5'd0, 12'h300), 64'h0000_0000_0000_0880, "R7");
    run(sys_ins(5'd2, 7'h18), 64'h0, "R7");
    rd_back(12'h300, "R7");
    chk("R7", "mode_is_S", mode_o, 2'b01);

    // R8 in supervisor: machine return illegal; R5 ecall cause 9
    run(sys_ins(5'd2, 7'h18), 64'h0, "R8");
    rd_back(12'h300, "R8");
    run(sys_ins(5'd0, 7'h00), 64'h0, "R5");

    // R6: supervisor return to user with bit5=0, bit1=1
    run(csr_ins(3'd1, 5'd1, 5'd0, 12'h100), 64'h0000_0000_0000_0002, "R6");
    run(sys_ins(5'd2, 7'h08), 64'h0, "R6");
    rd_back(12'h100, "R6");
    chk("R6", "mode_is_U", mode_o, 2'b00);

    // user mode: ecall 8, both returns illegal
    run(sys_ins(5'd0, 7'h00), 64'h0, "R5");
    run(sys_ins(5'd1, 7'h00), 64'h0, "R5");
    run(sys_ins(5'd2, 7'h08), 64'h0, "R8");
    run(sys_ins(5'd2, 7'h18), 64'h0, "R8");
    rd_back(12'h100, "R8");

    // R10 again after a mid-run reset
    do_reset();
    #1;
    chk("R10", "mode", mode_o, 2'b11);
    chk("R10", "paging", paging_on_o, 1'b0);
    rd_back(12'h180, "R10");
    rd_back(12'h7C2, "R10");

    // R6 from machine mode, bit8 set -> supervisor
    run(csr_ins(3'd1, 5'd1, 5'd0, 12'h100), 64'h0000_0000_0000_0120, "R6");
    run(sys_ins(5'd2, 7'h08), 64'h0, "R6");
    rd_back(12'h100, "R6");
    chk("R6", "mode_is_S", mode_o, 2'b01);
    do_reset();

    // R7: field 11 stays machine, field 10 gives user
    run(csr_ins(3'd1, 5'd1, 5'd0, 12'h300), 64'h0000_0000_0000_1808, "R7");
    run(sys_ins(5'd2, 7'h18), 64'h0, "R7");
    rd_back(12'h300, "R7");
    chk("R7", "mode_is_M", mode_o, 2'b11);
    run(csr_ins(3'd1, 5'd1, 5'd0, 12'h300), 64'h0000_0000_0000_1000, "R7");
    run(sys_ins(5'd2, 7'h18), 64'h0, "R7");
    chk("R7", "mode_is_U", mode_o, 2'b00);
    do_reset();

    // R9: no strobe, no effect
    @(negedge clk);
    insn_i = csr_ins(3'd1, 5'd1, 5'd0, 12'h7C0); rs1_val_i = 64'hDEAD_BEEF; valid_i = 1'b0;
    #1;
    chk("R9", "rd_we", rd_we_o, 1'b0);
    @(negedge clk);
    insn_i = csr_ins(3'd1, 5'd1, 5'd0, 12'h180); rs1_val_i = 64'h8000_0000_0000_0000;
    #1;
    chk("R9", "exc", exc_valid_o, 1'b0);
    @(negedge clk);
    insn_i = sys_ins(5'd2, 7'h18);
    #1;
    chk("R9", "redirect", redirect_o, 1'b0);
    @(negedge clk);
    #1;
    chk("R9", "paging", paging_on_o, 1'b0);
    chk("R9", "mode", mode_o, 2'b11);
    rd_back(12'h7C0, "R9");
    rd_back(12'h180, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule